// File: doc/BRIEF.md
# UART Transmitter with CTS Gating and Driver Enable

This block serialises bytes onto an asynchronous serial line using a fixed 8N1 frame. Bytes arrive over a valid/ready stream. A byte is accepted only when the shifter has no work left, or in the very last cycle of a stop bit. This lets a producer that keeps `s_valid_i` high send frames with no idle gap between them. While `s_ready_o` is low the producer must hold `s_valid_i` and `s_data_i` steady. Accepting a byte never depends on the value of `s_data_i`.

The block has two output-control modes, chosen by `mode_i`, which may only change while `busy_o` is low.
- **Flow-control mode (0):** a host clear-to-send input `cts_i` is passed through a flop synchroniser. It is checked once, at the point where a byte would start. Low lets the byte go. High parks the byte until the input drops. A frame that has already begun always runs to its stop bit.
- **Half-duplex mode (1):** `cts_i` is ignored. A driver-enable output `de_o` brackets every frame, so it can steer an RS-485 style transceiver. The same line can also drive the transceiver's active-low receive enable.

Top module: `serial_tx_flow`

## Requirements
- R1: During and after reset, with no byte pending: `tx_o` is high, `de_o` is low, `busy_o` is low and `s_ready_o` is high.
- R2: Frame shape and timing:
  - A frame is one start bit (low), then eight data bits with the least significant bit first, then one stop bit (high).
  - Each bit lasts CLKS_PER_BIT clock cycles.
  - When the byte is allowed to start, the start bit begins in the cycle right after the accepting clock edge.
- R3: `s_ready_o` is high only when the block is idle, or in the final cycle of a stop bit. It is low while a byte is held for CTS and while the start or data bits are being sent.
- R4: In mode 0, a byte is checked against the synchronised `cts_i` when it would start:
  - If the input is high, `tx_o` stays high with `busy_o` high.
  - Once the synchronised input is low, the start bit begins.
- R5: In mode 0, `cts_i` rising while a frame is in progress does not shorten or alter that frame. The next byte is held instead.
- R6: Every accepted byte is sent exactly once, in acceptance order. No frame is sent without a matching accepted byte.
- R7: In mode 1, `cts_i` has no effect, and `de_o` follows the frame:
  - `de_o` is high from the first cycle of the start bit through the last cycle of the stop bit.
  - `de_o` is low at all other times.
- R8: In mode 1, a byte accepted in a final stop cycle starts its start bit in the next cycle. `de_o` stays high across the boundary, so consecutive start bits are exactly 10×CLKS_PER_BIT cycles apart.
- R9: In mode 0, `de_o` stays low at all times.
- R10: `busy_o` rises on the edge that accepts a byte. It stays high until the stop bit of the last accepted byte is complete.
- R11: In mode 0, with `cts_i` held low, back-to-back bytes are sent with no idle gap. Consecutive start bits are 10×CLKS_PER_BIT cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = CTS flow control, 1 = half duplex with driver enable |
| s_valid_i | input | 1 | Byte stream valid |
| s_ready_o | output | 1 | Byte stream ready |
| s_data_i | input | 8 | Byte to transmit |
| cts_i | input | 1 | Host clear-to-send, low permits a byte to start (asynchronous) |
| tx_o | output | 1 | Serial data line, idles high |
| de_o | output | 1 | Transceiver driver enable (half-duplex mode) |
| busy_o | output | 1 | A byte is held or being transmitted |

## Verification
The bench builds the block with CLKS_PER_BIT = 6 and a two-stage synchroniser. With these values a frame is 60 cycles long, so a few hundred random frames fit in the cycle budget. Six cycles per bit also leave a distinct middle cycle in every bit for sampling.

The short frame makes three situations cheap to reach many times:
- a CTS rise partway through a frame;
- a byte offered exactly in the final stop cycle;
- a mode change between bursts.

These are the places where truncation, duplication or a dropped driver enable would appear.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned FRAME_DATA_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= RESET_VAL;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= RESET_VAL;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
  import sertx_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       hdx_i,
  input  logic                       cts_hold_i,
  input  logic                       bit_tick_i,
  input  logic                       in_valid_i,
  input  logic [FRAME_DATA_BITS-1:0] in_data_i,
  output logic                       in_ready_o,
  output logic                       restart_o,
  output logic                       tx_o,
  output logic                       line_active_o,
  output tx_state_e                  state_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_DATA_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_DATA_BITS - 1);

  tx_state_e                  st_q, st_d;
  logic [FRAME_DATA_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]           idx_q, idx_d;
  logic                       may_start;
  logic                       take;

  // Half duplex ignores CTS; flow control lets a byte start only on a low CTS
  assign may_start = hdx_i || !cts_hold_i;

  always_comb begin
    st_d       = st_q;
    sh_d       = sh_q;
    idx_d      = idx_q;
    in_ready_o = (st_q == ST_IDLE) || ((st_q == ST_STOP) && bit_tick_i);
    take       = in_valid_i && in_ready_o;
    unique case (st_q)
      ST_IDLE: begin
        if (take) begin
          sh_d = in_data_i;
          st_d = may_start ? ST_START : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (may_start) st_d = ST_START;
      end
      ST_START: begin
        if (bit_tick_i) begin
          st_d  = ST_DATA;
          idx_d = '0;
        end
      end
      ST_DATA: begin
        if (bit_tick_i) begin
          sh_d = sh_q >> 1;
          if (idx_q == LAST_IDX) st_d = ST_STOP;
          else                   idx_d = idx_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (bit_tick_i) begin
          if (take) begin
            sh_d = in_data_i;
            st_d = may_start ? ST_START : ST_HOLD;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  // Bit timer restarts on the edge that enters the start bit
  assign restart_o = (st_d == ST_START) && (st_q != ST_START);

  always_comb begin
    unique case (st_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  assign line_active_o = (st_q == ST_START) || (st_q == ST_DATA) || (st_q == ST_STOP);
  assign state_o       = st_q;
endmodule

// File: rtl/serial_tx_flow.sv
module serial_tx_flow
  import sertx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mode_i,
  input  logic                       s_valid_i,
  output logic                       s_ready_o,
  input  logic [FRAME_DATA_BITS-1:0] s_data_i,
  input  logic                       cts_i,
  output logic                       tx_o,
  output logic                       de_o,
  output logic                       busy_o
);
  logic      cts_sync;
  logic      bit_tick;
  logic      restart;
  logic      line_active;
  tx_state_e st_q;

  // Reset value high: nothing starts until a low CTS has been seen
  sertx_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_cts_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cts_i),
    .sync_o (cts_sync)
  );

  sertx_baud #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_o   (bit_tick)
  );

  sertx_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hdx_i        (mode_i),
    .cts_hold_i   (cts_sync),
    .bit_tick_i   (bit_tick),
    .in_valid_i   (s_valid_i),
    .in_data_i    (s_data_i),
    .in_ready_o   (s_ready_o),
    .restart_o    (restart),
    .tx_o         (tx_o),
    .line_active_o(line_active),
    .state_o      (st_q)
  );

  assign de_o   = mode_i && line_active;
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/serial_tx_flow_chk.sv
module serial_tx_flow_chk
  import sertx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      mode_i,
  input logic      s_valid_i,
  input logic      s_ready_o,
  input logic      tx_o,
  input logic      de_o,
  input logic      busy_o,
  input logic      cts_sync,
  input tx_state_e st_q
);
  assert_idle_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tx_o && !de_o));

  assert_no_ready_mid_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA || st_q == ST_HOLD) |-> !s_ready_o);

  assert_cts_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && !mode_i && cts_sync) |=> (st_q == ST_HOLD));

  assert_no_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START || st_q == ST_DATA) |=>
      (st_q == ST_START || st_q == ST_DATA || st_q == ST_STOP));

  assert_de_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && busy_o && !tx_o) |-> de_o);

  assert_de_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $fell(de_o)) |-> ($past(st_q) == ST_STOP));

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> busy_o);
endmodule

bind serial_tx_flow serial_tx_flow_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o),
  .tx_o     (tx_o),
  .de_o     (de_o),
  .busy_o   (busy_o),
  .cts_sync (cts_sync),
  .st_q     (st_q)
);

// File: tb/serial_tx_flow_tb_top.sv
module serial_tx_flow_tb_top;
  localparam int unsigned CPB   = 6;
  localparam int unsigned FRAME = 10 * CPB;

  logic       clk, rst_n, mode, s_valid, cts;
  logic [7:0] s_data;
  logic       s_ready, tx, de, busy;

  int  checks = 0;
  int  errors = 0;
  int  frames = 0;
  int  sent   = 0;
  longint cyc = 0;
  bit  rnd_cts = 0;
  logic [7:0] exp_q[$];
  longint starts[$];

  serial_tx_flow #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .cts_i(cts), .tx_o(tx), .de_o(de), .busy_o(busy)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  // Expected byte taken from bits 8..1: start bit, LSB-first data, stop bit
  function automatic logic [7:0] frame_data(input logic [9:0] b);
    return b[8:1];
  endfunction

  // Line monitor: detects a start bit and samples every bit in its middle cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        logic [9:0] bits;
        logic [7:0] e;
        bit de_ok;
        longint st_cyc;
        st_cyc = cyc;
        de_ok  = 1'b1;
        bits   = '0;
        for (int off = 0; off < FRAME; off++) begin
          if (off > 0) @(negedge clk);
          if (de !== mode) de_ok = 1'b0;
          if (off % CPB == CPB / 2) bits[off / CPB] = tx;
        end
        starts.push_back(st_cyc);
        frames++;
        chk(bits[0] == 1'b0 && bits[9] == 1'b1, "R2", "start/stop bits",
            {bits[9], bits[0]}, 2'b10);
        if (mode) chk(de_ok, "R7", "DE high across frame", de_ok, 1);
        else      chk(de_ok, "R9", "DE low in flow mode", de_ok, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "frame with no accepted byte", frame_data(bits), 0);
        end else begin
          e = exp_q.pop_front();
          chk(frame_data(bits) == e, "R2", "data byte LSB first", frame_data(bits), e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rnd_cts && ($urandom % 30 == 0)) cts = ~cts;
    end
  end

  task automatic send(input logic [7:0] b);
    s_valid = 1'b1;
    s_data  = b;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(b);
    sent++;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || exp_q.size() != 0);
    @(negedge clk);
  endtask

  initial begin
    int f0;
    int s0;
    bit held_ok;
    void'($urandom(32'h5EED_0011));
    rst_n = 1'b0; mode = 1'b0; s_valid = 1'b0; s_data = '0; cts = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx == 1'b1 && de == 1'b0, "R1", "line in reset", {tx, de}, 2'b10);
    chk(busy == 1'b0 && s_ready == 1'b1, "R1", "busy/ready in reset", {busy, s_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx == 1'b1 && de == 1'b0 && busy == 1'b0 && s_ready == 1'b1, "R1",
        "idle after reset", {tx, de, busy, s_ready}, 4'b1001);

    // R2, R10, R3: single byte, flow mode, CTS low
    send(8'hA5);
    chk(tx == 1'b0, "R2", "start bit in cycle after accept", tx, 0);
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    repeat (2 * CPB) @(negedge clk);
    chk(s_ready == 1'b0, "R3", "ready low during data bits", s_ready, 0);
    wait_idle();
    chk(busy == 1'b0, "R10", "busy cleared after stop", busy, 0);

    // R4: CTS high holds the byte
    cts = 1'b1;
    repeat (4) @(negedge clk);
    f0 = frames;
    send(8'h3C);
    held_ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (tx !== 1'b1 || busy !== 1'b1 || s_ready !== 1'b0) held_ok = 1'b0;
      @(negedge clk);
    end
    chk(held_ok, "R4", "line idle and busy while CTS high", held_ok, 1);
    chk(frames == f0, "R4", "no frame while held", frames, f0);
    cts = 1'b0;
    wait_idle();
    chk(frames == f0 + 1, "R4", "frame after CTS low", frames, f0 + 1);

    // R5, R6: CTS rises mid-frame
    f0 = frames;
    fork
      begin send(8'h81); send(8'h7E); end
      begin repeat (3 * CPB) @(negedge clk); cts = 1'b1; end
    join
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R5", "frame in flight completed", frames, f0 + 1);
    chk(tx == 1'b1 && busy == 1'b1, "R5", "next byte parked", {tx, busy}, 2'b11);
    cts = 1'b0;
    wait_idle();
    chk(frames == f0 + 2, "R6", "each byte sent once", frames, f0 + 2);

    // R7: half duplex ignores CTS, DE brackets frame
    mode = 1'b1;
    cts  = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h55);
    chk(de == 1'b1 && tx == 1'b0, "R7", "DE rises with start despite CTS high", {de, tx}, 2'b10);
    wait_idle();
    chk(de == 1'b0, "R7", "DE low after frame", de, 0);

    // R8: half-duplex back-to-back
    s0 = starts.size();
    send(8'h01); send(8'hFE); send(8'h96);
    wait_idle();
    chk(starts[s0+1] - starts[s0] == FRAME, "R8", "gap frame 1-2",
        starts[s0+1] - starts[s0], FRAME);
    chk(starts[s0+2] - starts[s0+1] == FRAME, "R8", "gap frame 2-3",
        starts[s0+2] - starts[s0+1], FRAME);

    // R11, R9: flow mode back-to-back with CTS tied low
    mode = 1'b0;
    cts  = 1'b0;
    repeat (4) @(negedge clk);
    s0 = starts.size();
    send(8'hC3); send(8'h00); send(8'hFF);
    wait_idle();
    chk(starts[s0+1] - starts[s0] == FRAME, "R11", "gap frame 1-2",
        starts[s0+1] - starts[s0], FRAME);
    chk(starts[s0+2] - starts[s0+1] == FRAME, "R11", "gap frame 2-3",
        starts[s0+2] - starts[s0+1], FRAME);

    // Random traffic: modes, gaps and CTS toggles (R6 ordering and count)
    f0 = frames;
    s0 = sent;
    for (int g = 0; g < 20; g++) begin
      rnd_cts = 1'b0;
      cts = 1'b0;
      wait_idle();
      mode = 1'($urandom % 2);
      repeat (3) @(negedge clk);
      rnd_cts = 1'b1;
      for (int k = 0; k < 10; k++) begin
        repeat ($urandom % 8) @(negedge clk);
        send(8'($urandom));
      end
    end
    rnd_cts = 1'b0;
    cts = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R6", "all accepted bytes sent", exp_q.size(), 0);
    chk(frames - f0 == sent - s0, "R6", "frame count matches accepts",
        frames - f0, sent - s0);
    finish_run();
  end
endmodule